// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry Out

This block is the combinational second-operand shifter of a data-processing datapath. It takes one operand word and produces the shifted word together with the shifter carry-out. The carry-out is the last bit moved out of the word. A logic unit and the flag-writeback stage, both outside this block, consume it. Four shift kinds are supported: logical left, logical right, arithmetic right and rotate right. The shift amount comes from one of two places: a 5-bit immediate field of the instruction, or the low byte of a register that the caller has already read.

A third form builds a constant. The low 8 bits of the operand are rotated right by twice a 4-bit field. Some amount values have special meanings. An immediate amount of zero stands for a full-width right shift, for a rotate by one bit through the carry, or for no shift at all, depending on the kind. Register amounts of zero, 32 and above 32 each have their own defined result. The current carry flag enters on `carry_i` and is used both for the one-bit rotate through carry and as the carry-out whenever nothing is shifted.

Top module: `oper_shifter`

## Requirements
- R1: With the immediate source and kind 0 (logical left, encoding kind_i = 0), an amount n of 1..31 gives result = operand << n and carry-out = operand bit 32−n.
- R2: With the immediate source and an amount n of 1..31, kind 1 (logical right) shifts in zeros, kind 2 (arithmetic right) shifts in copies of bit 31, and kind 3 (rotate right) feeds the low bits into the top. In all three cases carry-out = operand bit n−1.
- R3: An immediate logical left by 0 returns the operand unchanged, and carry-out equals carry_i.
- R4: An immediate logical right by 0 acts as a shift by 32: result 0, carry-out = operand bit 31.
- R5: An immediate arithmetic right by 0 acts as a shift by 32: every result bit and the carry-out equal operand bit 31.
- R6: An immediate rotate right by 0 is a one-bit rotate through carry: result = {carry_i, operand[31:1]}, carry-out = operand bit 0.
- R7: With the register source (use_reg_i = 1), the amount is the 8-bit reg_amt_i. An amount of 0 returns the operand and carry_i unchanged for every kind.
- R8: A register logical left or logical right by exactly 32 gives result 0. The carry-out is operand bit 0 for left and operand bit 31 for right.
- R9: A register logical left or logical right by 33..255 gives result 0 and carry-out 0.
- R10: A register arithmetic right by 1..31 behaves as in R2. By 32..255, every result bit and the carry-out equal operand bit 31.
- R11: A register rotate right by 1..255 rotates by the amount modulo 32. When that remainder is 0, the result is the operand and the carry-out is operand bit 31. Otherwise the carry-out is operand bit (remainder−1).
- R12: When rot_imm_i = 1 (this takes precedence over use_reg_i), the result is operand[7:0] zero-extended and rotated right by 2×imm_amt_i[4:1]. The carry-out is carry_i when that field is 0, and result bit 31 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 32 | Operand word; low 8 bits are the constant byte in the rotated-immediate form |
| kind_i | input | 2 | Shift kind: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right |
| imm_amt_i | input | 5 | Immediate shift amount; bits 4:1 are the rotate field of the constant form |
| reg_amt_i | input | 8 | Low byte of the amount register |
| use_reg_i | input | 1 | 1 selects reg_amt_i as the amount, 0 selects imm_amt_i |
| rot_imm_i | input | 1 | 1 selects the rotated 8-bit constant form |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted value |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The bench sweeps every kind against every immediate amount and every register byte, using operand words with distinct edge bits and both carry-in values. It also covers every rotate field of the constant form with several bytes. The zero-immediate encodings are the main target. A design that treated them as a plain zero shift would return the operand on logical or arithmetic right, and would miss the carry-in that the one-bit rotate feeds into bit 31. The register boundaries at 0, 32 and 33 are probed as well. A shifter that keeps only five bits of the register byte would wrap 32 to a pass-through and would give non-zero results above 32. It would also lose the sign fill on a long arithmetic shift. An off-by-one in the carry index shows up at once on these operand patterns.

// File: rtl/shift_pkg.sv
package shift_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/shift_decode.sv
// Turns the three amount sources into one normalized request for the core.
module shift_decode
  import shift_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = $clog2(WIDTH),
  parameter int REG_W = 8,
  parameter int ROT_W = 8,
  parameter int AMT_W = $clog2(WIDTH) + 1
) (
  input  logic [WIDTH-1:0] opnd_i,
  input  shift_kind_e      kind_i,
  input  logic [IMM_W-1:0] imm_amt_i,
  input  logic [REG_W-1:0] reg_amt_i,
  input  logic             use_reg_i,
  input  logic             rot_imm_i,
  output logic [WIDTH-1:0] val_o,
  output shift_kind_e      kind_o,
  output logic [AMT_W-1:0] amt_o,
  output logic             pass_o,
  output logic             rrx_o
);
  localparam logic [AMT_W-1:0] AMT_FULL = AMT_W'(WIDTH);
  localparam logic [AMT_W-1:0] AMT_OVER = AMT_W'(WIDTH + 1);
  localparam logic [REG_W-1:0] REG_FULL = REG_W'(WIDTH);

  always_comb begin
    val_o  = opnd_i;
    kind_o = kind_i;
    amt_o  = '0;
    pass_o = 1'b0;
    rrx_o  = 1'b0;
    if (rot_imm_i) begin
      // constant form: byte rotated by an even amount
      val_o  = {{(WIDTH-ROT_W){1'b0}}, opnd_i[ROT_W-1:0]};
      kind_o = SH_ROR;
      amt_o  = AMT_W'({imm_amt_i[IMM_W-1:1], 1'b0});
      pass_o = (imm_amt_i[IMM_W-1:1] == '0);
    end else if (!use_reg_i) begin
      if (imm_amt_i == '0) begin
        unique case (kind_i)
          SH_LSL:         pass_o = 1'b1;
          SH_LSR, SH_ASR: amt_o  = AMT_FULL;
          default:        rrx_o  = 1'b1;
        endcase
      end else begin
        amt_o = AMT_W'(imm_amt_i);
      end
    end else if (reg_amt_i == '0) begin
      pass_o = 1'b1;
    end else begin
      unique case (kind_i)
        SH_LSL, SH_LSR:
          amt_o = (reg_amt_i > REG_FULL) ? AMT_OVER : AMT_W'(reg_amt_i);
        SH_ASR:
          amt_o = (reg_amt_i >= REG_FULL) ? AMT_FULL : AMT_W'(reg_amt_i);
        default:
          amt_o = AMT_W'(reg_amt_i[IMM_W-1:0]);
      endcase
    end
  end
endmodule

// File: rtl/shift_core.sv
// Double-width shifter: the bit just outside the kept window is the carry.
module shift_core
  import shift_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = $clog2(WIDTH) + 1
) (
  input  logic [WIDTH-1:0] val_i,
  input  shift_kind_e      kind_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             pass_i,
  input  logic             rrx_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o
);
  localparam int DW = 2 * WIDTH;

  logic        [DW-1:0] wide_l;
  logic        [DW-1:0] wide_r;
  logic signed [DW-1:0] wide_a;
  logic        [DW-1:0] wide_d;

  always_comb begin
    wide_l = {{WIDTH{1'b0}}, val_i} << amt_i;
    wide_r = {val_i, {WIDTH{1'b0}}} >> amt_i;
    wide_a = $signed({val_i, {WIDTH{1'b0}}}) >>> amt_i;
    wide_d = {val_i, val_i} >> amt_i;
  end

  always_comb begin
    result_o = val_i;
    carry_o  = carry_i;
    if (rrx_i) begin
      result_o = {carry_i, val_i[WIDTH-1:1]};
      carry_o  = val_i[0];
    end else if (!pass_i) begin
      unique case (kind_i)
        SH_LSL: begin
          result_o = wide_l[WIDTH-1:0];
          carry_o  = wide_l[WIDTH];
        end
        SH_LSR: begin
          result_o = wide_r[DW-1:WIDTH];
          carry_o  = wide_r[WIDTH-1];
        end
        SH_ASR: begin
          result_o = wide_a[DW-1:WIDTH];
          carry_o  = wide_a[WIDTH-1];
        end
        default: begin
          result_o = wide_d[WIDTH-1:0];
          carry_o  = wide_d[WIDTH-1];
        end
      endcase
    end
  end
endmodule

// File: rtl/oper_shifter.sv
module oper_shifter
  import shift_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = $clog2(WIDTH),
  parameter int REG_W = 8,
  parameter int ROT_W = 8
) (
  input  logic [WIDTH-1:0] opnd_i,
  input  shift_kind_e      kind_i,
  input  logic [IMM_W-1:0] imm_amt_i,
  input  logic [REG_W-1:0] reg_amt_i,
  input  logic             use_reg_i,
  input  logic             rot_imm_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o
);
  localparam int AMT_W = $clog2(WIDTH) + 1;

  logic [WIDTH-1:0] norm_val;
  shift_kind_e      norm_kind;
  logic [AMT_W-1:0] norm_amt;
  logic             norm_pass;
  logic             norm_rrx;

  shift_decode #(
    .WIDTH(WIDTH), .IMM_W(IMM_W), .REG_W(REG_W), .ROT_W(ROT_W), .AMT_W(AMT_W)
  ) u_decode (
    .opnd_i   (opnd_i),
    .kind_i   (kind_i),
    .imm_amt_i(imm_amt_i),
    .reg_amt_i(reg_amt_i),
    .use_reg_i(use_reg_i),
    .rot_imm_i(rot_imm_i),
    .val_o    (norm_val),
    .kind_o   (norm_kind),
    .amt_o    (norm_amt),
    .pass_o   (norm_pass),
    .rrx_o    (norm_rrx)
  );

  shift_core #(
    .WIDTH(WIDTH), .AMT_W(AMT_W)
  ) u_core (
    .val_i   (norm_val),
    .kind_i  (norm_kind),
    .amt_i   (norm_amt),
    .pass_i  (norm_pass),
    .rrx_i   (norm_rrx),
    .carry_i (carry_i),
    .result_o(result_o),
    .carry_o (carry_o)
  );
endmodule

// File: rtl/oper_shifter_chk.sv
module oper_shifter_chk
  import shift_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = $clog2(WIDTH),
  parameter int REG_W = 8,
  parameter int ROT_W = 8
) (
  input logic [WIDTH-1:0] opnd_i,
  input shift_kind_e      kind_i,
  input logic [IMM_W-1:0] imm_amt_i,
  input logic [REG_W-1:0] reg_amt_i,
  input logic             use_reg_i,
  input logic             rot_imm_i,
  input logic             carry_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o
);
  logic imm_sel;
  logic reg_sel;
  assign imm_sel = !rot_imm_i && !use_reg_i;
  assign reg_sel = !rot_imm_i && use_reg_i;

  always_comb begin
    // R4
    imm_lsr_zero_chk: assert (!(imm_sel && kind_i == SH_LSR && imm_amt_i == '0)
                              || (result_o == '0 && carry_o == opnd_i[WIDTH-1]));
    // R6
    imm_rrx_chk: assert (!(imm_sel && kind_i == SH_ROR && imm_amt_i == '0)
                         || (result_o == {carry_i, opnd_i[WIDTH-1:1]} && carry_o == opnd_i[0]));
    // R7
    reg_zero_pass_chk: assert (!(reg_sel && reg_amt_i == '0)
                               || (result_o == opnd_i && carry_o == carry_i));
    // R9
    reg_overrun_chk: assert (!(reg_sel && (kind_i == SH_LSL || kind_i == SH_LSR)
                               && reg_amt_i > REG_W'(WIDTH))
                             || (result_o == '0 && !carry_o));
    // R12
    rot_const_bits_chk: assert (!rot_imm_i
                                || $countones(result_o) == $countones(opnd_i[ROT_W-1:0]));
  end
endmodule

bind oper_shifter oper_shifter_chk #(
  .WIDTH(WIDTH), .IMM_W(IMM_W), .REG_W(REG_W), .ROT_W(ROT_W)
) u_chk (.*);

// File: tb/tb_oper_shifter.sv
`timescale 1ns/1ps
module tb_oper_shifter;
  import shift_pkg::*;

  logic        clk;
  logic [31:0] opnd_i;
  shift_kind_e kind_i;
  logic [4:0]  imm_amt_i;
  logic [7:0]  reg_amt_i;
  logic        use_reg_i;
  logic        rot_imm_i;
  logic        carry_i;
  logic [31:0] result_o;
  logic        carry_o;

  int checks;
  int failures;

  oper_shifter dut (
    .opnd_i   (opnd_i),
    .kind_i   (kind_i),
    .imm_amt_i(imm_amt_i),
    .reg_amt_i(reg_amt_i),
    .use_reg_i(use_reg_i),
    .rot_imm_i(rot_imm_i),
    .carry_i  (carry_i),
    .result_o (result_o),
    .carry_o  (carry_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] pats [6];
  initial begin
    pats[0] = 32'h8000_0001;
    pats[1] = 32'h7FFF_FFFE;
    pats[2] = 32'hA5C3_0F96;
    pats[3] = 32'h0000_0000;
    pats[4] = 32'hFFFF_FFFF;
    pats[5] = 32'h1234_5678;
  end

  // Bit-serial model: one step per position, carry = last bit dropped.
  function automatic void model(input logic [31:0] v, input int k, input int imm,
                                input int ra, input bit ur, input bit ri, input bit ci,
                                output logic [31:0] res, output logic co);
    int n;
    res = v;
    co  = ci;
    if (ri) begin
      res = {24'd0, v[7:0]};
      n = (imm / 2) * 2;
      for (int i = 0; i < n; i++) begin
        res = {res[0], res[31:1]};
        co  = res[31];
      end
      return;
    end
    if (!ur && imm == 0) begin
      case (k)
        0: begin res = v; co = ci; end
        1: begin res = 32'd0; co = v[31]; end
        2: begin res = {32{v[31]}}; co = v[31]; end
        default: begin res = {ci, v[31:1]}; co = v[0]; end
      endcase
      return;
    end
    n = ur ? ra : imm;
    for (int i = 0; i < n; i++) begin
      case (k)
        0: begin co = res[31]; res = {res[30:0], 1'b0}; end
        1: begin co = res[0]; res = {1'b0, res[31:1]}; end
        2: begin co = res[0]; res = {res[31], res[31:1]}; end
        default: begin co = res[0]; res = {res[0], res[31:1]}; end
      endcase
    end
  endfunction

  function automatic string tag_of(input int k, input int imm, input int ra,
                                   input bit ur, input bit ri);
    if (ri) return "R12";
    if (!ur) begin
      if (imm == 0) begin
        case (k)
          0: return "R3";
          1: return "R4";
          2: return "R5";
          default: return "R6";
        endcase
      end
      return (k == 0) ? "R1" : "R2";
    end
    if (ra == 0) return "R7";
    if (k == 3) return "R11";
    if (k == 2) return "R10";
    if (ra == 32) return "R8";
    if (ra > 32) return "R9";
    return (k == 0) ? "R1" : "R2";
  endfunction

  task automatic run_one(input logic [31:0] v, input int k, input int imm, input int ra,
                         input bit ur, input bit ri, input bit ci);
    logic [31:0] exp_r;
    logic        exp_c;
    @(posedge clk);
    #1;
    opnd_i    = v;
    kind_i    = shift_kind_e'(k[1:0]);
    imm_amt_i = imm[4:0];
    reg_amt_i = ra[7:0];
    use_reg_i = ur;
    rot_imm_i = ri;
    carry_i   = ci;
    @(negedge clk);
    model(v, k, imm, ra, ur, ri, ci, exp_r, exp_c);
    checks++;
    if (result_o !== exp_r || carry_o !== exp_c) begin
      failures++;
      $display("FAIL %s v=%h k=%0d imm=%0d reg=%0d ur=%0b ri=%0b ci=%0b: got %h/%0b exp %h/%0b",
               tag_of(k, imm, ra, ur, ri), v, k, imm, ra, ur, ri, ci,
               result_o, carry_o, exp_r, exp_c);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0;
    failures = 0;
    // initial state: all-zero inputs, a pass-through of zero (R3)
    run_one(32'd0, 0, 0, 0, 1'b0, 1'b0, 1'b0);
    // immediate sweep: R1..R6
    for (int k = 0; k < 4; k++)
      for (int imm = 0; imm < 32; imm++)
        for (int p = 0; p < 6; p++)
          for (int c = 0; c < 2; c++)
            run_one(pats[p], k, imm, 0, 1'b0, 1'b0, c[0]);
    // register sweep: R7..R11 plus R1/R2 for in-range amounts
    for (int k = 0; k < 4; k++)
      for (int ra = 0; ra < 256; ra++)
        for (int p = 0; p < 6; p++)
          for (int c = 0; c < 2; c++)
            run_one(pats[p], k, 7, ra, 1'b1, 1'b0, c[0]);
    // rotated constant: R12, with use_reg_i set too to show precedence
    for (int imm = 0; imm < 32; imm++)
      for (int p = 0; p < 6; p++)
        for (int c = 0; c < 2; c++)
          run_one(pats[p], imm % 4, imm, 33, c[0], 1'b1, c[0]);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule